// File: doc/BRIEF.md
# Fuse Shadow Load Controller

This block copies a write-once fuse image into a bank of shadow configuration registers. It does this once after reset and again whenever software asks for it. A load only goes ahead when the parity of three load-enable fuses is odd. Burning one of those fuses turns loading on, a second turns it off again, and a third turns it back on. While loading is off, the shadow registers keep whatever the host wrote into them, so a configuration can be tried out before any fuse is burned.

The last bank holds a few startup settings, each stored as several redundant copies: a sequencer clock select (2 bits), a switcher slew select (2 bits) and a power-button mode (1 bit). The value that takes effect is the XOR of all the copies, which lets a setting be changed more than once on storage that can only be written once. The block reads these settings from the shadow registers, so values written by the host drive them too. ECC correction happens upstream: the fuse image arrives already corrected.

A reload is requested by writing a trigger bit, which clears itself when the reload starts. A power-control bit chooses whether the reload first asserts a power-off window or goes straight to copying. A load walks the banks one per cycle. A done flag reports the end of the sweep, and host writes are refused while the block is busy.

Top module: `fuse_load_ctrl`

## Requirements
- R1: A load (at power-up or on request) runs only when the XOR of the three load-enable fuses is 1. These fuses sit at bits [COPIES*5+2 : COPIES*5] of the last bank (bits 12..10 by default). When the XOR is 0 the request is dropped, no sweep runs, and the shadow keeps the values the host wrote.
- R2: After reset is released, if loading is enabled, a sweep starts on its own. After the sweep, shadow bank b equals fuse bank b for every b, and `load_done` is high at the NUM_BANKS+1-th rising edge after release.
- R3: The outputs `cfg_seq_clk`, `cfg_slew` and `cfg_pwron` are the XOR of the COPIES copies held in the last shadow bank. Copy k occupies bits [5k+4:5k]. Within a copy, bits [1:0] are the sequencer clock, [3:2] the slew select and [4] the power-button mode.
- R4: A write on `mask_we` with bit 7 of `mask_data` set raises `reload_pend`. A write with bit 7 clear does not start a reload.
- R5: `reload_pend` clears on the rising edge at which the reload is accepted, and `busy` rises on that same edge.
- R6: While the power-cycle enable is set (its reset value is 1), an accepted reload holds `pwr_off` high for exactly PWROFF_CYC cycles before the sweep.
- R7: A write on `pctl_we` sets the power-cycle enable to bit 0 of `pctl_data`. With that bit 0, a reload goes straight to the sweep and `pwr_off` never rises.
- R8: A host write (`host_we`, `host_bank`, `host_data`) updates the addressed shadow bank only while `busy` is low. While busy it is ignored.
- R9: `load_done` clears when a sweep starts and sets when the last bank has been copied.
- R10: During reset the shadow is all zeros, and `busy`, `pwr_off`, `reload_pend` and `load_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fuse_bits | input | NUM_BANKS*BANK_W | Corrected fuse image, bank b at [b*BANK_W +: BANK_W] |
| host_we | input | 1 | Host write strobe for a shadow bank |
| host_bank | input | IDX_W | Shadow bank index for the host write |
| host_data | input | BANK_W | Host write data |
| mask_we | input | 1 | Load-mask write strobe |
| mask_data | input | CTRL_W | Load-mask data, bit 7 requests a reload |
| pctl_we | input | 1 | Power-control write strobe |
| pctl_data | input | CTRL_W | Power-control data, bit 0 is the power-cycle enable |
| shadow_bits | output | NUM_BANKS*BANK_W | Shadow register contents, same layout as the fuse image |
| cfg_seq_clk | output | 2 | Effective sequencer clock select |
| cfg_slew | output | 2 | Effective switcher slew select |
| cfg_pwron | output | 1 | Effective power-button mode |
| reload_pend | output | 1 | Reload requested and not yet started |
| pwr_off | output | 1 | Power-off window before a reload |
| busy | output | 1 | Power-off window or sweep in progress |
| load_done | output | 1 | Last sweep completed |

## Verification
The assertions assume that the fuse image stays still while a sweep is running and that the load-enable fuses are stable from the cycle before a load is accepted. A real fuse array behaves this way, and the assertion tying the start of a load to the gate depends on it. The stimulus changes `fuse_bits` only while the block is idle, and it sets the image before reset is released. The assertions also assume that host and control strobes are single-cycle pulses. The bench issues every write as a one-cycle pulse driven just after a clock edge.

// File: rtl/fuse_ld_pkg.sv
package fuse_ld_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_PWROFF = 2'd1,
      ST_SWEEP  = 2'd2
   } ld_state_e;

   // Width of one redundant configuration copy and count of load-enable fuses
   localparam int CFG_FIELD_W = 5;
   localparam int GATE_FUSES  = 3;
endpackage

// File: rtl/fuse_ld_gate.sv
module fuse_ld_gate #(
   parameter int N_FUSES = 3
) (
   input  logic [N_FUSES-1:0] gate_fuses_i,
   output logic               load_gate_o
);
   generate
      if (N_FUSES < 1) begin : g_bad
         $error("fuse_ld_gate: N_FUSES must be at least 1");
      end
   endgenerate

   // Odd parity of the enable fuses permits a load
   always_comb load_gate_o = ^gate_fuses_i;

   always_comb begin
      assert_gate_known_R1: assert (!$isunknown(gate_fuses_i) -> !$isunknown(load_gate_o));
   end
endmodule

// File: rtl/fuse_ld_fold.sv
module fuse_ld_fold #(
   parameter int COPIES = 2,
   parameter int FW     = 5
) (
   input  logic [COPIES*FW-1:0] copies_i,
   output logic [FW-1:0]        folded_o
);
   generate
      if (COPIES < 1) begin : g_bad
         $error("fuse_ld_fold: COPIES must be at least 1");
      end
      if (COPIES == 1) begin : g_single
         always_comb folded_o = copies_i;
      end else begin : g_chain
         logic [FW-1:0] acc [COPIES];
         always_comb acc[0] = copies_i[0 +: FW];
         for (genvar k = 1; k < COPIES; k++) begin : g_stage
            always_comb acc[k] = acc[k-1] ^ copies_i[k*FW +: FW];
         end
         always_comb folded_o = acc[COPIES-1];
      end
   endgenerate
endmodule

// File: rtl/fuse_ld_seq.sv
module fuse_ld_seq
   import fuse_ld_pkg::*;
#(
   parameter int NUM_BANKS  = 10,
   parameter int PWROFF_CYC = 16,
   parameter int CTRL_W     = 8,
   parameter int TRIG_BIT   = 7,
   parameter int PCEN_BIT   = 0,
   localparam int IDX_W     = $clog2(NUM_BANKS),
   localparam int CNT_W     = $clog2(PWROFF_CYC + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_gate_i,
   input  logic              mask_we_i,
   input  logic [CTRL_W-1:0] mask_data_i,
   input  logic              pctl_we_i,
   input  logic [CTRL_W-1:0] pctl_data_i,
   output logic              busy_o,
   output logic              pwr_off_o,
   output logic              reload_pend_o,
   output logic              load_done_o,
   output logic              load_we_o,
   output logic [IDX_W-1:0]  load_idx_o
);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_BANKS - 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PWROFF_CYC - 1);

   generate
      if (TRIG_BIT >= CTRL_W || PCEN_BIT >= CTRL_W) begin : g_bad_bits
         $error("fuse_ld_seq: control bit positions exceed CTRL_W");
      end
      if (PWROFF_CYC < 1) begin : g_bad_win
         $error("fuse_ld_seq: PWROFF_CYC must be at least 1");
      end
   endgenerate

   ld_state_e        st_q;
   logic [IDX_W-1:0] idx_q;
   logic [CNT_W-1:0] cnt_q;
   logic             done_q, pend_q, por_req_q, pc_en_q;
   logic             trig_set;
   logic             unused_ctrl;

   always_comb trig_set    = mask_we_i && mask_data_i[TRIG_BIT];
   always_comb unused_ctrl = ^{mask_data_i, pctl_data_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         idx_q     <= '0;
         cnt_q     <= '0;
         done_q    <= 1'b0;
         pend_q    <= 1'b0;
         por_req_q <= 1'b1;
         pc_en_q   <= 1'b1;
      end else begin
         if (pctl_we_i) pc_en_q <= pctl_data_i[PCEN_BIT];
         unique case (st_q)
            ST_IDLE: begin
               if (por_req_q) begin
                  por_req_q <= 1'b0;
                  if (load_gate_i) begin
                     st_q   <= ST_SWEEP;
                     idx_q  <= '0;
                     done_q <= 1'b0;
                  end
               end else if (pend_q) begin
                  pend_q <= 1'b0;
                  if (load_gate_i) begin
                     idx_q  <= '0;
                     cnt_q  <= '0;
                     done_q <= 1'b0;
                     st_q   <= pc_en_q ? ST_PWROFF : ST_SWEEP;
                  end
               end
            end
            ST_PWROFF: begin
               if (cnt_q == CNT_LAST) st_q <= ST_SWEEP;
               else                   cnt_q <= cnt_q + 1'b1;
            end
            ST_SWEEP: begin
               if (idx_q == IDX_LAST) begin
                  st_q   <= ST_IDLE;
                  done_q <= 1'b1;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
         // A new request written this cycle wins over the clear above
         if (trig_set) pend_q <= 1'b1;
      end
   end

   always_comb begin
      busy_o        = (st_q != ST_IDLE);
      pwr_off_o     = (st_q == ST_PWROFF);
      reload_pend_o = pend_q;
      load_done_o   = done_q;
      load_we_o     = (st_q == ST_SWEEP);
      load_idx_o    = idx_q;
   end

   // R1: leaving idle requires the gate in the cycle of the decision
   assert_start_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != ST_IDLE && $past(st_q) == ST_IDLE) |-> $past(load_gate_i));

   // R5: an accepted pending request is cleared on the next edge
   assert_pend_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE && !por_req_q && pend_q && !trig_set) |=> !pend_q);

   // R6: the power-off window ends only after its full count
   assert_pwroff_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_off_o) |-> ($past(cnt_q) == CNT_LAST && st_q == ST_SWEEP));

   // R7: a power-off window opens only with the enable set
   assert_pwroff_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_off_o) |-> $past(pc_en_q));

   // R9: done rises only at the end of the last bank
   assert_done_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(load_done_o) |-> $past(st_q == ST_SWEEP && idx_q == IDX_LAST));
endmodule

// File: rtl/fuse_ld_shadow.sv
module fuse_ld_shadow #(
   parameter int NUM_BANKS = 10,
   parameter int BANK_W    = 20,
   localparam int IDX_W    = $clog2(NUM_BANKS),
   localparam int IMG_W    = NUM_BANKS * BANK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy_i,
   input  logic              load_we_i,
   input  logic [IDX_W-1:0]  load_idx_i,
   input  logic [IMG_W-1:0]  fuse_bits_i,
   input  logic              host_we_i,
   input  logic [IDX_W-1:0]  host_bank_i,
   input  logic [BANK_W-1:0] host_data_i,
   output logic [IMG_W-1:0]  shadow_bits_o
);
   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         logic [BANK_W-1:0] bank_q;
         logic              sel_load, sel_host;
         always_comb sel_load = load_we_i && (load_idx_i == IDX_W'(b));
         always_comb sel_host = host_we_i && !busy_i && (host_bank_i == IDX_W'(b));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        bank_q <= '0;
            else if (sel_load) bank_q <= fuse_bits_i[b*BANK_W +: BANK_W];
            else if (sel_host) bank_q <= host_data_i;
         end
         always_comb shadow_bits_o[b*BANK_W +: BANK_W] = bank_q;
      end
   endgenerate

   // R8: while busy and not copying, nothing (host included) alters the shadow
   assert_host_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && !load_we_i) |=> $stable(shadow_bits_o));
endmodule

// File: rtl/fuse_load_ctrl.sv
module fuse_load_ctrl
   import fuse_ld_pkg::*;
#(
   parameter int NUM_BANKS  = 10,
   parameter int BANK_W     = 20,
   parameter int COPIES     = 2,
   parameter int PWROFF_CYC = 16,
   parameter int CTRL_W     = 8,
   localparam int IDX_W     = $clog2(NUM_BANKS),
   localparam int IMG_W     = NUM_BANKS * BANK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IMG_W-1:0]  fuse_bits,
   input  logic              host_we,
   input  logic [IDX_W-1:0]  host_bank,
   input  logic [BANK_W-1:0] host_data,
   input  logic              mask_we,
   input  logic [CTRL_W-1:0] mask_data,
   input  logic              pctl_we,
   input  logic [CTRL_W-1:0] pctl_data,
   output logic [IMG_W-1:0]  shadow_bits,
   output logic [1:0]        cfg_seq_clk,
   output logic [1:0]        cfg_slew,
   output logic              cfg_pwron,
   output logic              reload_pend,
   output logic              pwr_off,
   output logic              busy,
   output logic              load_done
);
   localparam int CFG_BASE  = (NUM_BANKS - 1) * BANK_W;
   localparam int COPY_BITS = COPIES * CFG_FIELD_W;
   localparam int GATE_POS  = CFG_BASE + COPY_BITS;

   generate
      if (NUM_BANKS < 2) begin : g_bad_nb
         $error("fuse_load_ctrl: NUM_BANKS must be at least 2");
      end
      if (COPY_BITS + GATE_FUSES > BANK_W) begin : g_bad_fit
         $error("fuse_load_ctrl: redundant fields do not fit the last bank");
      end
      if (CTRL_W < 8) begin : g_bad_ctrl
         $error("fuse_load_ctrl: CTRL_W must hold the trigger bit");
      end
   endgenerate

   logic                   load_gate;
   logic                   load_we;
   logic [IDX_W-1:0]       load_idx;
   logic [CFG_FIELD_W-1:0] cfg_eff;

   fuse_ld_gate #(.N_FUSES(GATE_FUSES)) u_gate (
      .gate_fuses_i (fuse_bits[GATE_POS +: GATE_FUSES]),
      .load_gate_o  (load_gate)
   );

   fuse_ld_seq #(
      .NUM_BANKS (NUM_BANKS), .PWROFF_CYC (PWROFF_CYC), .CTRL_W (CTRL_W),
      .TRIG_BIT  (7),         .PCEN_BIT   (0)
   ) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .load_gate_i   (load_gate),
      .mask_we_i     (mask_we),
      .mask_data_i   (mask_data),
      .pctl_we_i     (pctl_we),
      .pctl_data_i   (pctl_data),
      .busy_o        (busy),
      .pwr_off_o     (pwr_off),
      .reload_pend_o (reload_pend),
      .load_done_o   (load_done),
      .load_we_o     (load_we),
      .load_idx_o    (load_idx)
   );

   fuse_ld_shadow #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_shadow (
      .clk           (clk),
      .rst_n         (rst_n),
      .busy_i        (busy),
      .load_we_i     (load_we),
      .load_idx_i    (load_idx),
      .fuse_bits_i   (fuse_bits),
      .host_we_i     (host_we),
      .host_bank_i   (host_bank),
      .host_data_i   (host_data),
      .shadow_bits_o (shadow_bits)
   );

   fuse_ld_fold #(.COPIES(COPIES), .FW(CFG_FIELD_W)) u_fold (
      .copies_i (shadow_bits[CFG_BASE +: COPY_BITS]),
      .folded_o (cfg_eff)
   );

   always_comb begin
      cfg_seq_clk = cfg_eff[1:0];
      cfg_slew    = cfg_eff[3:2];
      cfg_pwron   = cfg_eff[4];
   end

   // R2: no sweep may be in progress while done is reported
   assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load_done |-> !busy);
endmodule

// File: tb/fuse_load_ctrl_tb.sv
module fuse_load_ctrl_tb;
   localparam int NB    = 10;
   localparam int BW    = 20;
   localparam int PWOFF = 16;
   localparam int IMG   = NB * BW;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [IMG-1:0] fuse_bits = '0;
   logic           host_we = 1'b0;
   logic [3:0]     host_bank = '0;
   logic [BW-1:0]  host_data = '0;
   logic           mask_we = 1'b0;
   logic [7:0]     mask_data = '0;
   logic           pctl_we = 1'b0;
   logic [7:0]     pctl_data = '0;
   logic [IMG-1:0] shadow_bits;
   logic [1:0]     cfg_seq_clk, cfg_slew;
   logic           cfg_pwron, reload_pend, pwr_off, busy, load_done;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   fuse_load_ctrl #(.NUM_BANKS(NB), .BANK_W(BW), .COPIES(2), .PWROFF_CYC(PWOFF), .CTRL_W(8)) u_dut (
      .clk (clk), .rst_n (rst_n), .fuse_bits (fuse_bits),
      .host_we (host_we), .host_bank (host_bank), .host_data (host_data),
      .mask_we (mask_we), .mask_data (mask_data), .pctl_we (pctl_we), .pctl_data (pctl_data),
      .shadow_bits (shadow_bits), .cfg_seq_clk (cfg_seq_clk), .cfg_slew (cfg_slew),
      .cfg_pwron (cfg_pwron), .reload_pend (reload_pend), .pwr_off (pwr_off),
      .busy (busy), .load_done (load_done)
   );

   // Vector: [18:16] enable fuses, [15:11] copy 0, [10:6] copy 1, [5] load expected, [4:0] cfg expected
   localparam logic [18:0] VEC [8] = '{
      {3'b001, 5'b10110, 5'b00011, 1'b1, 5'b10101},
      {3'b011, 5'b11111, 5'b00000, 1'b0, 5'b01101},
      {3'b111, 5'b01010, 5'b11001, 1'b1, 5'b10011},
      {3'b010, 5'b00000, 5'b11111, 1'b1, 5'b11111},
      {3'b000, 5'b11111, 5'b00000, 1'b0, 5'b01101},
      {3'b100, 5'b00111, 5'b00100, 1'b1, 5'b00011},
      {3'b101, 5'b10000, 5'b00000, 1'b0, 5'b01101},
      {3'b110, 5'b00001, 5'b10001, 1'b0, 5'b01101}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [IMG-1:0] mk_image(input int seed, input logic [BW-1:0] cfg_bank);
      logic [IMG-1:0] img;
      for (int b = 0; b < NB - 1; b++)
         img[b*BW +: BW] = BW'(32'h12340 ^ (b << 12) ^ seed);
      img[(NB-1)*BW +: BW] = cfg_bank;
      return img;
   endfunction

   function automatic logic [BW-1:0] cfg_bank_of(input logic [2:0] en, input logic [4:0] c0, input logic [4:0] c1);
      return {7'b0, en, c1, c0};
   endfunction

   task automatic host_write(input logic [3:0] bank, input logic [BW-1:0] data);
      @(posedge clk); #1;
      host_we = 1'b1; host_bank = bank; host_data = data;
      @(posedge clk); #1;
      host_we = 1'b0;
   endtask

   task automatic mask_write(input logic [7:0] d);
      @(posedge clk); #1;
      mask_we = 1'b1; mask_data = d;
      @(posedge clk); #1;
      mask_we = 1'b0;
   endtask

   task automatic pctl_write(input logic [7:0] d);
      @(posedge clk); #1;
      pctl_we = 1'b1; pctl_data = d;
      @(posedge clk); #1;
      pctl_we = 1'b0;
   endtask

   task automatic wait_idle();
      for (int n = 0; n < 100; n++) begin
         @(negedge clk);
         if (!busy && !reload_pend) break;
      end
   endtask

   initial begin
      #(200000 * 4);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int edges;
      int pw_cnt;
      logic [IMG-1:0] img;

      // Reset with loading disabled (enable fuses 000)
      img = mk_image(0, cfg_bank_of(3'b000, 5'b10101, 5'b00000));
      fuse_bits = img;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R10 shadow in reset", 32'(shadow_bits == '0), 32'd1);
      chk("R10 flags in reset", {28'd0, busy, pwr_off, reload_pend, load_done}, 32'd0);
      @(posedge clk); #1 rst_n = 1'b1;
      repeat (20) @(negedge clk);
      chk("R1 gated power-up leaves shadow", 32'(shadow_bits == '0), 32'd1);
      chk("R1 gated power-up no done", 32'(load_done), 32'd0);

      // Reset with loading enabled: exact latency and copy
      rst_n = 1'b0;
      img = mk_image(5, cfg_bank_of(3'b001, 5'b10101, 5'b00000));
      fuse_bits = img;
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
      edges = 0;
      for (int n = 0; n < 50; n++) begin
         @(posedge clk); edges++;
         @(negedge clk);
         if (load_done) break;
      end
      chk("R2 power-up done latency", 32'(edges), 32'(NB + 1));
      chk("R2 power-up shadow equals fuses", 32'(shadow_bits == img), 32'd1);
      chk("R3 power-up folded cfg", {27'd0, cfg_pwron, cfg_slew, cfg_seq_clk}, 32'h15);

      // Reloads without power cycle
      pctl_write(8'h00);
      for (int i = 0; i < 8; i++) begin
         logic [18:0] v;
         logic [BW-1:0] bank0_host;
         v = VEC[i];
         bank0_host = BW'(32'hABC00 + i);
         host_write(4'(NB - 1), BW'(20'h0000D));
         host_write(4'd0, bank0_host);
         img = mk_image(i * 3 + 1, cfg_bank_of(v[18:16], v[15:11], v[10:6]));
         fuse_bits = img;
         mask_write(8'h80);
         pw_cnt = 0;
         for (int n = 0; n < NB + 8; n++) begin
            @(negedge clk);
            if (pwr_off) pw_cnt++;
         end
         chk($sformatf("R1 R3 vector %0d cfg", i), {27'd0, cfg_pwron, cfg_slew, cfg_seq_clk}, {27'd0, v[4:0]});
         chk($sformatf("R1 R2 vector %0d bank0", i), 32'(shadow_bits[0 +: BW]),
             32'(v[5] ? img[0 +: BW] : bank0_host));
         chk($sformatf("R7 vector %0d no power-off", i), 32'(pw_cnt), 32'd0);
      end

      // Load enabled for the directed tests below
      img = mk_image(77, cfg_bank_of(3'b100, 5'b00110, 5'b00000));
      fuse_bits = img;

      // R4: trigger bit clear does nothing
      mask_write(8'h7F);
      @(negedge clk);
      chk("R4 bit7 clear no pending", 32'(reload_pend), 32'd0);
      @(negedge clk);
      chk("R4 bit7 clear no busy", 32'(busy), 32'd0);

      // R5: pending clears as the reload starts
      mask_write(8'h80);
      @(negedge clk);
      chk("R5 pending after write", {30'd0, reload_pend, busy}, 32'h2);
      @(negedge clk);
      chk("R5 pending cleared at start", {30'd0, reload_pend, busy}, 32'h1);
      chk("R9 done cleared at start", 32'(load_done), 32'd0);
      wait_idle();
      chk("R9 done after sweep", 32'(load_done), 32'd1);

      // R6 and R8: power-cycled reload, host write during power-off refused
      pctl_write(8'h01);
      mask_write(8'h80);
      @(negedge clk);
      @(negedge clk);
      chk("R6 power-off begins", 32'(pwr_off), 32'd1);
      host_write(4'd0, BW'(20'h55555));
      @(negedge clk);
      chk("R8 host write ignored while busy", 32'(shadow_bits[0 +: BW]), 32'(img[0 +: BW]));
      wait_idle();

      img = mk_image(91, cfg_bank_of(3'b010, 5'b00001, 5'b00000));
      fuse_bits = img;
      mask_write(8'h80);
      pw_cnt = 0;
      for (int n = 0; n < PWOFF + NB + 10; n++) begin
         @(negedge clk);
         if (pwr_off) pw_cnt++;
      end
      chk("R6 power-off length", 32'(pw_cnt), 32'(PWOFF));
      chk("R6 shadow after power-cycled reload", 32'(shadow_bits == img), 32'd1);

      // R8: host write accepted when idle
      host_write(4'd2, BW'(20'h0F0F0));
      @(negedge clk);
      chk("R8 host write when idle", 32'(shadow_bits[2*BW +: BW]), 32'h0F0F0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule